// File: doc/BRIEF.md
# Ordered Threshold Dither, Ten to Eight Bits per Channel

This block narrows a stream of 30-bit RGB pixels, ten bits per colour, to 24-bit pixels with eight bits per colour. It does not simply drop the two lowest bits. For each channel it compares those two bits with a threshold taken from a 2x2 ordered matrix. The matrix position comes from the pixel's column and row parity. When the dropped bits beat the threshold, the kept eight bits are rounded up by one step, and the result never wraps past full scale.

A 2-bit mode input chooses how the matrix is used:
- plain truncation;
- a fixed spatial pattern;
- a pattern whose thresholds shift on alternate frames;
- a pattern whose thresholds shift by a pseudo-random amount drawn from an internal shift register.

The block follows three inputs (line-valid, frame-active and a per-pixel ready pulse) to track its own column parity, row parity and frame toggle. It changes state only for pixels that arrive while a line and a frame are both active. Results appear one clock later, together with a ready flag.

Top module: `dither10to8`

## Requirements
- R1: The input pixel holds red in bits [29:20], green in [19:10] and blue in [9:0]. The output holds red in [23:16], green in [15:8] and blue in [7:0]. Each output channel starts from the upper eight bits of its input channel.
- R2: The base threshold is 2*row_parity + col_parity, which gives 0,1 on even rows and 2,3 on odd rows. A channel is incremented only when its two low input bits are strictly greater than the effective threshold.
- R3: An increment on a channel whose upper eight bits are all ones leaves the output at 255, with no wrap.
- R4: Mode 00 outputs the upper eight bits of every channel unchanged.
- R5: Mode 01 uses the base threshold with a rotation offset of 0.
- R6: Mode 10 adds an offset of 2, modulo 4, to the base threshold while the frame toggle is 1, and an offset of 0 while it is 0.
- R7: Mode 11 adds the low two bits of a 16-bit LFSR, modulo 4, to the base threshold.
  - The LFSR resets to 0xACE1.
  - Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}.
  - It steps on each accepted pixel at row parity 1 and column parity 1, in every mode.
- R8: A pixel is accepted only when pix_rdy, line_valid and frame_active are all high. Otherwise, in the next cycle, out_rdy is 0 and pix_out keeps its value.
- R9: The output of an accepted pixel appears on pix_out, with out_rdy high, in the cycle after the one in which the pixel is accepted.
- R10: Parity and frame tracking update as follows:
  - Column parity toggles on every accepted pixel and is cleared whenever line_valid is low.
  - Row parity toggles on each falling edge of line_valid.
  - A falling edge of frame_active clears row parity and inverts the frame toggle.
- R11: Reset is synchronous and active high. It clears pix_out, out_rdy, both parities and the frame toggle, and loads the LFSR seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 truncate, 01 spatial, 10 frame-rotated, 11 random-rotated |
| line_valid | input | 1 | High across the active part of a line |
| pix_rdy | input | 1 | Pulse marking a pixel on pix_in |
| frame_active | input | 1 | High across an active frame |
| pix_in | input | 30 | Ten-bit R, G, B input pixel |
| pix_out | output | 24 | Eight-bit R, G, B dithered pixel |
| out_rdy | output | 1 | High for one cycle with each output pixel |

## Verification
The bench covers the following corner cases:
- **Full-scale inputs with the top low-bit codes.** An adder without saturation would wrap these to zero.
- **Low bits equal to the threshold.** A design that compares with greater-or-equal would round these up.
- **Row changes at line ends and the frame-toggle rotation.** Parity kept in the wrong place would misplace the matrix or leave the temporal pattern frozen.
- **Pulses outside an active line or frame.** A block that does not gate on both would emit pixels or disturb the output.
- **Long random-mode runs checked against an independent LFSR model.** These catch wrong taps and steps taken at the wrong matrix position.

// File: rtl/dither_pkg.sv
package dither_pkg;

    localparam int NCH       = 3;
    localparam int DITH_BITS = 2;
    localparam int LFSR_W    = 16;

    typedef enum logic [1:0] {
        DM_OFF      = 2'b00,
        DM_SPATIAL  = 2'b01,
        DM_TEMPORAL = 2'b10,
        DM_RANDOM   = 2'b11
    } dmode_e;

    typedef struct packed {
        logic frm;
        logic row;
        logic col;
    } pos_t;

    function automatic logic [DITH_BITS-1:0] pick_thr(
        input pos_t                 p,
        input dmode_e               m,
        input logic [DITH_BITS-1:0] rnd
    );
        logic [DITH_BITS-1:0] off;
        case (m)
            DM_TEMPORAL: off = {p.frm, 1'b0};
            DM_RANDOM:   off = rnd;
            default:     off = '0;
        endcase
        return {p.row, p.col} + off;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/dither_pos_track.sv
module dither_pos_track
    import dither_pkg::*;
#(
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_valid,
    input  logic                 frame_active,
    input  logic                 take,
    output pos_t                 pos,
    output logic [DITH_BITS-1:0] rnd
);
    logic              lv_q, fa_q;
    logic [LFSR_W-1:0] lfsr;

    always_ff @(posedge clk) begin
        if (rst) begin
            lv_q <= 1'b0;
            fa_q <= 1'b0;
            pos  <= '0;
            lfsr <= LFSR_SEED;
        end else begin
            lv_q <= line_valid;
            fa_q <= frame_active;
            if (!line_valid)
                pos.col <= 1'b0;
            else if (take)
                pos.col <= ~pos.col;
            if (fa_q && !frame_active) begin
                pos.row <= 1'b0;
                pos.frm <= ~pos.frm;
            end else if (lv_q && !line_valid) begin
                pos.row <= ~pos.row;
            end
            if (take && pos.row && pos.col)
                lfsr <= lfsr_next(lfsr);
        end
    end

    assign rnd = lfsr[DITH_BITS-1:0];

    // R10: column parity cleared outside a line
    a_r10_col_clear: assert property (@(posedge clk) disable iff (rst)
        !line_valid |=> pos.col == 1'b0);
    // R10: frame end clears row and flips the frame toggle
    a_r10_frame_flip: assert property (@(posedge clk) disable iff (rst)
        (fa_q && !frame_active) |=> (pos.row == 1'b0 && pos.frm != $past(pos.frm)));
    // R10: row parity moves only on a line end
    a_r10_row_hold: assert property (@(posedge clk) disable iff (rst)
        (frame_active && !(lv_q && !line_valid)) |=> $stable(pos.row));
    // R7: shift register never locks up at zero
    a_r7_lfsr_live: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);
endmodule

// File: rtl/dither_chan.sv
module dither_chan
    import dither_pkg::*;
#(
    parameter int OUT_W = 8,
    parameter int IN_W  = OUT_W + DITH_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 bypass,
    input  logic [DITH_BITS-1:0] thr,
    input  logic [IN_W-1:0]      din,
    output logic [OUT_W-1:0]     dout
);
    logic [OUT_W-1:0]     hi;
    logic [DITH_BITS-1:0] lo;
    logic                 bump;

    assign hi   = din[IN_W-1:DITH_BITS];
    assign lo   = din[DITH_BITS-1:0];
    assign bump = !bypass && (lo > thr) && (hi != {OUT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (take)
            dout <= hi + OUT_W'(bump);
    end

    // R3: full-scale input never wraps
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (take && hi == {OUT_W{1'b1}}) |=> dout == {OUT_W{1'b1}});
    // R4: disabled mode truncates
    a_r4_trunc: assert property (@(posedge clk) disable iff (rst)
        (take && bypass) |=> dout == $past(hi));
    // R2: result is the kept bits or one step above
    a_r2_step_bound: assert property (@(posedge clk) disable iff (rst)
        take |=> (dout == $past(hi) || dout == $past(hi) + 1'b1));
endmodule

// File: rtl/dither10to8.sv
module dither10to8
    import dither_pkg::*;
#(
    parameter int                OUT_W     = 8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [1:0]                     mode,
    input  logic                           line_valid,
    input  logic                           pix_rdy,
    input  logic                           frame_active,
    input  logic [NCH*(OUT_W+DITH_BITS)-1:0] pix_in,
    output logic [NCH*OUT_W-1:0]           pix_out,
    output logic                           out_rdy
);
    localparam int IN_W = OUT_W + DITH_BITS;

    logic                 take;
    dmode_e               md;
    pos_t                 pos;
    logic [DITH_BITS-1:0] rnd;
    logic [DITH_BITS-1:0] thr;

    assign take = pix_rdy && line_valid && frame_active;
    assign md   = dmode_e'(mode);
    assign thr  = pick_thr(pos, md, rnd);

    dither_pos_track #(.LFSR_SEED(LFSR_SEED)) u_pos (
        .clk          (clk),
        .rst          (rst),
        .line_valid   (line_valid),
        .frame_active (frame_active),
        .take         (take),
        .pos          (pos),
        .rnd          (rnd)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dither_chan #(.OUT_W(OUT_W), .IN_W(IN_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .take   (take),
            .bypass (md == DM_OFF),
            .thr    (thr),
            .din    (pix_in[ch*IN_W +: IN_W]),
            .dout   (pix_out[ch*OUT_W +: OUT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_rdy <= 1'b0;
        else
            out_rdy <= take;
    end

    // R8: nothing accepted means no ready and a held pixel
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> (!out_rdy && $stable(pix_out)));
    // R9: ready follows an accepted pixel by one cycle
    a_r9_ready_follows: assert property (@(posedge clk) disable iff (rst)
        take |=> out_rdy);
endmodule

// File: tb/dither10to8_tb.sv
`timescale 1ns/1ps
module dither10to8_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b01;
    logic        line_valid = 1'b0;
    logic        pix_rdy = 1'b0;
    logic        frame_active = 1'b0;
    logic [29:0] pix_in = '0;
    logic [23:0] pix_out;
    logic        out_rdy;

    int n_chk = 0;
    int n_err = 0;

    // model state, from R2, R6, R7, R10
    logic        m_row, m_col, m_frm;
    logic [15:0] m_lfsr;
    logic [23:0] last_out;

    always #10 clk = ~clk;

    dither10to8 u_dut (
        .clk(clk), .rst(rst), .mode(mode), .line_valid(line_valid),
        .pix_rdy(pix_rdy), .frame_active(frame_active), .pix_in(pix_in),
        .pix_out(pix_out), .out_rdy(out_rdy)
    );

    // spatial mode vectors: {R,G,B in, R,G,B expected}; rows 0 then 1, cols 0,1,0,1
    localparam logic [53:0] VEC [0:7] = '{
        {10'h3FF, 10'h001, 10'h000, 8'hFF, 8'h01, 8'h00},
        {10'h005, 10'h006, 10'h3FE, 8'h01, 8'h02, 8'hFF},
        {10'h200, 10'h203, 10'h3FC, 8'h80, 8'h81, 8'hFF},
        {10'h0FF, 10'h0FD, 10'h102, 8'h40, 8'h3F, 8'h41},
        {10'h00B, 10'h00A, 10'h3FF, 8'h03, 8'h02, 8'hFF},
        {10'h3FF, 10'h013, 10'h000, 8'hFF, 8'h04, 8'h00},
        {10'h2AB, 10'h155, 10'h3FE, 8'hAB, 8'h55, 8'hFF},
        {10'h1FF, 10'h0C2, 10'h3FD, 8'h7F, 8'h30, 8'hFF}
    };

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ch(input logic [9:0] v, input logic [1:0] thr, input logic [1:0] md);
        if (md == 2'b00) return v[9:2];
        if (v[1:0] > thr && v[9:2] != 8'hFF) return v[9:2] + 8'd1;
        return v[9:2];
    endfunction

    function automatic logic [23:0] model(input logic [29:0] p);
        logic [1:0] off, thr;
        case (mode)
            2'b10:   off = m_frm ? 2'd2 : 2'd0;
            2'b11:   off = m_lfsr[1:0];
            default: off = 2'd0;
        endcase
        thr = {m_row, m_col} + off;
        return {exp_ch(p[29:20], thr, mode), exp_ch(p[19:10], thr, mode), exp_ch(p[9:0], thr, mode)};
    endfunction

    task automatic px(input logic [29:0] p, input bit use_tab, input logic [23:0] tab, input string tag);
        logic [23:0] e;
        @(negedge clk);
        e = use_tab ? tab : model(p);
        pix_in  = p;
        pix_rdy = 1'b1;
        @(negedge clk);
        pix_rdy = 1'b0;
        chk(out_rdy == 1'b1, {tag, " R9 ready"}, {23'd0, out_rdy}, 24'd1);
        chk(pix_out == e, tag, pix_out, e);
        last_out = e;
        if (m_row && m_col) m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        m_col = ~m_col;
    endtask

    task automatic end_line();
        @(negedge clk);
        line_valid = 1'b0;
        pix_rdy    = 1'b1;
        pix_in     = ~pix_in;
        @(negedge clk);
        pix_rdy = 1'b0;
        chk(out_rdy == 1'b0 && pix_out == last_out, "R8 ignored with line_valid low", pix_out, last_out);
        line_valid = 1'b1;
        m_row = ~m_row;
        m_col = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk);
        line_valid   = 1'b0;
        frame_active = 1'b0;
        @(negedge clk);
        @(negedge clk);
        frame_active = 1'b1;
        @(negedge clk);
        line_valid = 1'b1;
        m_row = 1'b0;
        m_col = 1'b0;
        m_frm = ~m_frm;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        m_row = 0; m_col = 0; m_frm = 0; m_lfsr = 16'hACE1; last_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pix_out == 24'd0, "R11 reset pix_out", pix_out, 24'd0);
        chk(out_rdy == 1'b0, "R11 reset out_rdy", {23'd0, out_rdy}, 24'd0);

        // R8: pulses outside an active frame/line
        pix_in = 30'h3FFFFFFF; pix_rdy = 1'b1;
        @(negedge clk);
        chk(out_rdy == 1'b0 && pix_out == 24'd0, "R8 ignored outside frame", pix_out, 24'd0);
        frame_active = 1'b1;
        @(negedge clk);
        pix_rdy = 1'b0;
        chk(out_rdy == 1'b0 && pix_out == 24'd0, "R8 ignored outside line", pix_out, 24'd0);
        line_valid = 1'b1;

        // R1 R2 R3 R5: spatial table
        mode = 2'b01;
        for (int i = 0; i < 8; i++) begin
            if (i == 4) end_line();
            px(VEC[i][53:24], 1'b1, VEC[i][23:0], "R1 R2 R3 R5 spatial vector");
        end
        @(negedge clk);
        chk(out_rdy == 1'b0 && pix_out == last_out, "R8 hold between pixels", pix_out, last_out);

        // R6 R10: frame toggle set, offset 2
        end_frame();
        mode = 2'b10;
        for (int i = 0; i < 8; i++) begin
            if (i == 4) end_line();
            px({10'(i * 4 + 3), 10'(i * 4 + 2), 10'(i * 4 + 1)}, 1'b0, '0, "R6 R10 temporal frame 1");
        end
        end_frame();
        for (int i = 0; i < 4; i++)
            px({10'(i * 4 + 3), 10'(i * 4 + 2), 10'(i * 4 + 1)}, 1'b0, '0, "R6 R10 temporal frame 0");

        // R4: truncation
        mode = 2'b00;
        for (int i = 0; i < 4; i++)
            px({10'h3FF, 10'(i * 8 + 3), 10'h2FF}, 1'b0, '0, "R4 disabled truncation");

        // R7: random rotation over several lines
        mode = 2'b11;
        for (int i = 0; i < 96; i++) begin
            if (i != 0 && i % 8 == 0) end_line();
            px({10'(i * 37 + 5), 10'(i * 91 + 2), 10'(i * 13 + 3)}, 1'b0, '0, "R7 random rotation");
        end
        end_frame();
        px(30'h3FFFFFFF, 1'b0, '0, "R3 R7 saturation random");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule